// File: doc/BRIEF.md
# Command Sequencer for an 8-bit Controller Core

This block steers one command at a time through a small 8-bit controller core. A command byte arrives over a valid/ready handshake while the sequencer is idle. It is held on a dedicated output for an external combinational decoder, which answers with a 7-bit opcode and a 2-bit length code. The length code says how many operand bytes follow the command byte. The sequencer pulls those bytes from an operand stream into a small buffer, then carries out the command.

Opcodes fall into three classes. An arithmetic/logic opcode runs a fixed memory–ALU–memory sequence. A control/transfer opcode is only announced on a flag output, and the rest of the core acts on it. One reserved opcode value marks a byte the decoder does not recognise. That command is aborted at once with an error indication. No operand is fetched and neither memory nor the ALU is touched.

Every command ends with a one-cycle completion pulse, and the sequencer then returns to idle. The last decoded opcode, its length code and the operand bytes stay visible on outputs until the next command is accepted.

Top module: `instr_seq`

## Requirements
- R1: While reset is active and just after it, the sequencer is idle (`cmd_ready` = 1), `cur_opcode` = 7'b1101111, `cur_len` = 2'b00, `opr_bytes` = 0, and no strobe (`mem_rd`, `mem_wr`, `alu_valid`, `ctl_flag`, `done`, `err`) is high. A reset in the middle of a command abandons it.
- R2: A command byte is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only in idle, so it stays low from acceptance until the cycle after `done`.
- R3: The number of operand bytes taken equals the number of ones in the length code: 00 takes none, 01 and 10 take one, 11 takes two. `cur_len` shows the decoded code.
- R4: The first operand byte lands in `opr_bytes[7:0]` and the second in `opr_bytes[15:8]`. Both are cleared when a new command is accepted.
- R5: Opcode 7'b1101111 gives `err` = 1 in the same cycle as `done`, whatever its length code. No operand byte is taken, and there is no `mem_rd`, `mem_wr`, `alu_valid` or `ctl_flag` for that command.
- R6: An opcode at or below ALU_OP_MAX (default 47) is arithmetic/logic. Any other valid opcode is control: it gives exactly one `ctl_flag` pulse, no memory or ALU activity, and then `done`.
- R7: An arithmetic/logic command runs in this order. One `mem_rd` pulse at address `opr_bytes[7:0]`. `mem_rdata` is captured at the end of the next cycle. One `alu_valid` pulse follows with `alu_a` = the captured byte and `alu_op` = the opcode. The sequencer waits for `alu_res_valid` and captures `alu_result`. One `mem_wr` pulse then writes that result to the same address.
- R8: `mem_rd` and `mem_wr` last one cycle each and are never high together.
- R9: Each accepted command produces exactly one `done` pulse, one cycle long.
- R10: Operand collection and the ALU wait both stall for as long as `opr_valid` or `alu_res_valid` stays low, without losing or duplicating a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Command byte |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| dec_byte | output | 8 | Held command byte to the decoder |
| dec_opcode | input | 7 | Opcode returned by the decoder |
| dec_len | input | 2 | Length code returned by the decoder |
| opr_valid | input | 1 | Operand byte offered |
| opr_byte | input | 8 | Operand byte |
| opr_ready | output | 1 | Sequencer is collecting operand bytes |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address (first operand byte) |
| mem_wdata | output | 8 | Data written to memory |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| alu_valid | output | 1 | Operand and opcode presented to the ALU |
| alu_op | output | 7 | Opcode for the ALU |
| alu_a | output | 8 | Operand byte for the ALU |
| alu_res_valid | input | 1 | ALU result present |
| alu_result | input | 8 | ALU result |
| ctl_flag | output | 1 | Control/transfer command pulse |
| done | output | 1 | Command complete |
| err | output | 1 | Command was unrecognised (with `done`) |
| cur_opcode | output | 7 | Held decoded opcode |
| cur_len | output | 2 | Held decoded length code |
| opr_bytes | output | 16 | Operand buffer, first byte low |

## Verification
The bench sweeps all 256 command bytes through a decoder model whose opcode and length follow arithmetically from the byte. Byte 0xFF carries both the reserved opcode and length code 11. A design that checked the length before the opcode would wait forever for two operand bytes there, or would touch memory. Length code 10 must take one byte; a design that read only the low bit would take none, and one that counted it as three would hang. Commands with no operand must leave the buffer cleared after a two-operand command, which catches a buffer that is never cleared. The sweep also varies ALU latency and gaps in the operand stream. A sequencer that does not stall would write a stale result or store an operand twice. A reset taken during operand collection must drop the half-filled buffer and restore the invalid opcode.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_OPERAND,
        ST_DISPATCH,
        ST_RD,
        ST_RDWAIT,
        ST_ALU,
        ST_WAIT,
        ST_WR,
        ST_CTL,
        ST_DONE
    } iseq_state_e;

    typedef enum logic [1:0] {
        CL_INVALID,
        CL_CONTROL,
        CL_ARITH
    } iseq_class_e;

endpackage

// File: rtl/iseq_lenmap.sv
module iseq_lenmap #(
    parameter int LEN_W = 2,
    parameter int CNT_W = 2
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Operand count is the number of set bits in the code, so an
    // unlisted code still terminates with a bounded count.
    logic [CNT_W-1:0] part [LEN_W+1];

    assign part[0] = '0;

    for (genvar g = 0; g < LEN_W; g++) begin : g_bit
        assign part[g+1] = part[g] + CNT_W'(len_i[g]);
    end

    assign cnt_o = part[LEN_W];
endmodule

// File: rtl/iseq_classify.sv
module iseq_classify
    import iseq_pkg::*;
#(
    parameter int OP_W       = 7,
    parameter int ALU_OP_MAX = 47,
    parameter int INVALID_OP = 111
) (
    input  logic [OP_W-1:0] op_i,
    output iseq_class_e     cls_o
);
    localparam logic [OP_W-1:0] ALU_LIMIT = OP_W'(ALU_OP_MAX);
    localparam logic [OP_W-1:0] BAD_CODE  = OP_W'(INVALID_OP);

    always_comb begin
        if (op_i == BAD_CODE) begin
            cls_o = CL_INVALID;
        end else if (op_i <= ALU_LIMIT) begin
            cls_o = CL_ARITH;
        end else begin
            cls_o = CL_CONTROL;
        end
    end
endmodule

// File: rtl/iseq_opbuf.sv
module iseq_opbuf #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 2,
    parameter int IDX_W  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic [SLOTS*DATA_W-1:0] slots_o
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] byte_d;
        logic [DATA_W-1:0] byte_q;

        always_comb begin
            byte_d = byte_q;
            if (clr_i) begin
                byte_d = '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
                byte_d = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign slots_o[s*DATA_W +: DATA_W] = byte_q;
    end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import iseq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OP_W       = 7,
    parameter int LEN_W      = 2,
    parameter int ALU_OP_MAX = 47,
    parameter int INVALID_OP = 111
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [DATA_W-1:0]       cmd_byte,
    output logic                    cmd_ready,
    output logic [DATA_W-1:0]       dec_byte,
    input  logic [OP_W-1:0]         dec_opcode,
    input  logic [LEN_W-1:0]        dec_len,
    input  logic                    opr_valid,
    input  logic [DATA_W-1:0]       opr_byte,
    output logic                    opr_ready,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [DATA_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    alu_valid,
    output logic [OP_W-1:0]         alu_op,
    output logic [DATA_W-1:0]       alu_a,
    input  logic                    alu_res_valid,
    input  logic [DATA_W-1:0]       alu_result,
    output logic                    ctl_flag,
    output logic                    done,
    output logic                    err,
    output logic [OP_W-1:0]         cur_opcode,
    output logic [LEN_W-1:0]        cur_len,
    output logic [LEN_W*DATA_W-1:0] opr_bytes
);
    // The largest count a LEN_W-bit code can map to is LEN_W.
    localparam int NUM_OPR = LEN_W;
    localparam int CNT_W   = $clog2(NUM_OPR + 1);
    localparam int IDX_W   = (NUM_OPR > 1) ? $clog2(NUM_OPR) : 1;

    typedef struct packed {
        iseq_state_e       st;
        iseq_class_e       cls;
        logic [OP_W-1:0]   op;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  rem;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] rdat;
        logic [DATA_W-1:0] res;
        logic              err;
    } seq_regs_t;

    seq_regs_t   cur_q;
    seq_regs_t   nxt_d;
    logic [CNT_W-1:0] load_cnt;
    iseq_class_e dec_cls;
    logic        buf_clr;
    logic        buf_we;

    iseq_lenmap #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_lenmap (
        .len_i (dec_len),
        .cnt_o (load_cnt)
    );

    iseq_classify #(
        .OP_W       (OP_W),
        .ALU_OP_MAX (ALU_OP_MAX),
        .INVALID_OP (INVALID_OP)
    ) u_classify (
        .op_i  (dec_opcode),
        .cls_o (dec_cls)
    );

    iseq_opbuf #(
        .DATA_W (DATA_W),
        .SLOTS  (NUM_OPR),
        .IDX_W  (IDX_W)
    ) u_opbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (buf_we),
        .wr_idx_i  (cur_q.idx),
        .wr_data_i (opr_byte),
        .slots_o   (opr_bytes)
    );

    always_comb begin
        nxt_d   = cur_q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    nxt_d.cmd = cmd_byte;
                    nxt_d.err = 1'b0;
                    nxt_d.idx = '0;
                    buf_clr   = 1'b1;
                    nxt_d.st  = ST_DECODE;
                end
            end
            ST_DECODE: begin
                nxt_d.op  = dec_opcode;
                nxt_d.len = dec_len;
                nxt_d.cls = dec_cls;
                nxt_d.rem = load_cnt;
                if (dec_cls == CL_INVALID) begin
                    nxt_d.err = 1'b1;
                    nxt_d.st  = ST_DONE;
                end else if (load_cnt != '0) begin
                    nxt_d.st = ST_OPERAND;
                end else begin
                    nxt_d.st = ST_DISPATCH;
                end
            end
            ST_OPERAND: begin
                if (opr_valid) begin
                    buf_we    = 1'b1;
                    nxt_d.idx = cur_q.idx + IDX_W'(1);
                    nxt_d.rem = cur_q.rem - CNT_W'(1);
                    if (cur_q.rem == CNT_W'(1)) begin
                        nxt_d.st = ST_DISPATCH;
                    end
                end
            end
            ST_DISPATCH: begin
                nxt_d.st = (cur_q.cls == CL_ARITH) ? ST_RD : ST_CTL;
            end
            ST_RD: begin
                nxt_d.st = ST_RDWAIT;
            end
            ST_RDWAIT: begin
                nxt_d.rdat = mem_rdata;
                nxt_d.st   = ST_ALU;
            end
            ST_ALU: begin
                nxt_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (alu_res_valid) begin
                    nxt_d.res = alu_result;
                    nxt_d.st  = ST_WR;
                end
            end
            ST_WR: begin
                nxt_d.st = ST_DONE;
            end
            ST_CTL: begin
                nxt_d.st = ST_DONE;
            end
            ST_DONE: begin
                nxt_d.st = ST_IDLE;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.cls  <= CL_INVALID;
            cur_q.op   <= OP_W'(INVALID_OP);
            cur_q.len  <= '0;
            cur_q.rem  <= '0;
            cur_q.idx  <= '0;
            cur_q.cmd  <= '0;
            cur_q.rdat <= '0;
            cur_q.res  <= '0;
            cur_q.err  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cmd_ready  = (cur_q.st == ST_IDLE);
    assign dec_byte   = cur_q.cmd;
    assign opr_ready  = (cur_q.st == ST_OPERAND);
    assign mem_rd     = (cur_q.st == ST_RD);
    assign mem_wr     = (cur_q.st == ST_WR);
    assign mem_addr   = opr_bytes[DATA_W-1:0];
    assign mem_wdata  = cur_q.res;
    assign alu_valid  = (cur_q.st == ST_ALU);
    assign alu_op     = cur_q.op;
    assign alu_a      = cur_q.rdat;
    assign ctl_flag   = (cur_q.st == ST_CTL);
    assign done       = (cur_q.st == ST_DONE);
    assign err        = done && cur_q.err;
    assign cur_opcode = cur_q.op;
    assign cur_len    = cur_q.len;
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic opr_ready,
    input logic mem_rd,
    input logic mem_wr,
    input logic alu_valid,
    input logic alu_res_valid,
    input logic ctl_flag,
    input logic done,
    input logic err
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R8
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready); // R2
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R5
    AST_ERR_NO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(opr_ready)); // R5
    AST_ALU_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |-> $past(mem_rd, 2)); // R7
    AST_WR_AFTER_RES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(alu_res_valid)); // R7
    AST_CTL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_flag, mem_rd, mem_wr, alu_valid, opr_ready, cmd_ready})); // R6
endmodule

bind instr_seq iseq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ready     (cmd_ready),
    .opr_ready     (opr_ready),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .alu_valid     (alu_valid),
    .alu_res_valid (alu_res_valid),
    .ctl_flag      (ctl_flag),
    .done          (done),
    .err           (err)
);

// File: tb/tb_instr_seq.sv
module tb_instr_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_ready;
    logic [7:0]  dec_byte;
    logic [6:0]  dec_opcode;
    logic [1:0]  dec_len;
    logic        opr_valid = 1'b0;
    logic [7:0]  opr_byte = '0;
    logic        opr_ready;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_addr, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        alu_valid;
    logic [6:0]  alu_op;
    logic [7:0]  alu_a;
    logic        alu_res_valid = 1'b0;
    logic [7:0]  alu_result = '0;
    logic        ctl_flag, done, err;
    logic [6:0]  cur_opcode;
    logic [1:0]  cur_len;
    logic [15:0] opr_bytes;

    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Decoder model: byte 0xFF is unrecognised, else opcode = byte[7:2].
    assign dec_opcode = (dec_byte == 8'hFF) ? 7'b1101111 : {1'b0, dec_byte[7:2]};
    assign dec_len    = dec_byte[1:0];

    instr_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .dec_byte(dec_byte), .dec_opcode(dec_opcode), .dec_len(dec_len),
        .opr_valid(opr_valid), .opr_byte(opr_byte), .opr_ready(opr_ready),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alu_valid(alu_valid), .alu_op(alu_op), .alu_a(alu_a),
        .alu_res_valid(alu_res_valid), .alu_result(alu_result),
        .ctl_flag(ctl_flag), .done(done), .err(err),
        .cur_opcode(cur_opcode), .cur_len(cur_len), .opr_bytes(opr_bytes)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One command, observed and driven at falling edges only.
    task automatic run_cmd(input logic [7:0] c, input logic [7:0] o0,
                           input logic [7:0] o1, input int lat, input bit stall);
        bit         inv;
        int         nopr_exp;
        bit         arith;
        logic [6:0] op_exp;
        logic [7:0] addr_exp;
        logic [7:0] old_val;
        logic [7:0] seen_a;
        logic [6:0] seen_op;
        int n_opr = 0, n_rd = 0, n_wr = 0, n_alu = 0, n_ctl = 0;
        int n_err = 0, n_overlap = 0, n_busy_rdy = 0, acnt = 0, cyc = 0;
        bit took = 0, accepted = 0, finished = 0;

        inv      = (c == 8'hFF);
        op_exp   = inv ? 7'b1101111 : {1'b0, c[7:2]};
        nopr_exp = inv ? 0 : (int'(c[1]) + int'(c[0]));
        arith    = !inv && (op_exp <= 7'd47);
        addr_exp = (nopr_exp >= 1) ? o0 : 8'h00;
        old_val  = mem[addr_exp];
        seen_a   = '0;
        seen_op  = '0;

        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = c;
        while (!finished && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (took) begin
                cmd_valid = 1'b0;
                accepted  = 1;
            end
            took = cmd_valid && cmd_ready;
            if (accepted && cmd_ready) n_busy_rdy++;
            opr_valid = stall ? cyc[0] : 1'b1;
            opr_byte  = (n_opr == 0) ? o0 : o1;
            if (opr_ready && opr_valid) n_opr++;
            if (mem_rd && mem_wr) n_overlap++;
            if (mem_rd) begin
                n_rd++;
                mem_rdata = mem[mem_addr];
            end
            if (mem_wr) begin
                n_wr++;
                mem[mem_addr] = mem_wdata;
            end
            alu_res_valid = 1'b0;
            if (alu_valid) begin
                n_alu++;
                seen_a  = alu_a;
                seen_op = alu_op;
                acnt    = lat;
            end else if (acnt > 0) begin
                acnt--;
                if (acnt == 0) begin
                    alu_res_valid = 1'b1;
                    alu_result    = seen_a + {1'b0, seen_op};
                end
            end
            if (ctl_flag) n_ctl++;
            if (err) n_err++;
            if (done) finished = 1;
        end
        opr_valid = 1'b0;
        chk("R9 done reached", int'(finished), 1);
        chk("R2 ready low while busy", n_busy_rdy, 0);
        chk("R3 operand bytes taken", n_opr, nopr_exp);
        chk("R3 held length code", int'(cur_len), int'(c[1:0]));
        chk("R5 error flag", n_err, int'(inv));
        chk("R5 held opcode", int'(cur_opcode), int'(op_exp));
        chk("R6 control flag pulses", n_ctl, int'(!inv && !arith));
        chk("R7 read pulses", n_rd, int'(arith));
        chk("R7 alu pulses", n_alu, int'(arith));
        chk("R7 write pulses", n_wr, int'(arith));
        chk("R8 read/write overlap", n_overlap, 0);
        chk("R4 low operand", int'(opr_bytes[7:0]), int'(addr_exp));
        chk("R4 high operand", int'(opr_bytes[15:8]), (nopr_exp == 2) ? int'(o1) : 0);
        if (arith) begin
            chk("R7 alu operand", int'(seen_a), int'(old_val));
            chk("R7 alu opcode", int'(seen_op), int'(op_exp));
            chk("R7 stored result", int'(mem[addr_exp]), int'(8'(old_val + {1'b0, op_exp})));
        end else begin
            chk("R5 R6 memory untouched", int'(mem[addr_exp]), int'(old_val));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1 ready in reset", int'(cmd_ready), 1);
        chk("R1 opcode in reset", int'(cur_opcode), 7'h6F);
        chk("R1 strobes in reset", int'({mem_rd, mem_wr, alu_valid, ctl_flag, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 length after reset", int'(cur_len), 0);
        chk("R1 operands after reset", int'(opr_bytes), 0);

        // Full sweep of command bytes, varying ALU latency and operand gaps (R10).
        for (int c = 0; c < 256; c++) begin
            run_cmd(8'(c), 8'(c) ^ 8'h5A, ~8'(c), 1 + (c % 3), c[3]);
        end
        // Length code 10 and 11 again with long stalls (R10).
        run_cmd(8'h06, 8'h11, 8'h22, 5, 1'b1);
        run_cmd(8'h07, 8'h33, 8'h44, 7, 1'b1);

        // R1: reset during operand collection abandons the command.
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h0B;
        @(negedge clk);
        cmd_valid = 1'b0;
        opr_valid = 1'b1;
        opr_byte  = 8'hAA;
        @(negedge clk);
        @(negedge clk);
        chk("R1 precondition operand stored", int'(opr_bytes[7:0]), 8'hAA);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready after mid reset", int'(cmd_ready), 1);
        chk("R1 opcode after mid reset", int'(cur_opcode), 7'h6F);
        chk("R1 length after mid reset", int'(cur_len), 0);
        chk("R1 operands after mid reset", int'(opr_bytes), 0);
        opr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(8'h05, 8'h10, 8'h00, 1, 1'b0);
        summary();
    end
endmodule